// File: doc/BRIEF.md
# Complex Lane Arithmetic Unit

This block is a SIMD datapath that treats each vector as a row of complex numbers packed into adjacent lane pairs. In every pair the lower (even) lane carries the real part and the upper (odd) lane carries the imaginary part. A three-bit opcode picks one of eight operations: two rotated additions, plain and conjugate complex multiply, and plain and conjugate complex multiply with an added or subtracted third operand.

All operands are signed two's-complement integers of the lane width. Every result wraps to that width, and there is no saturation. The unit is a fixed two-stage pipeline. It accepts a new operation on every cycle that `in_valid` is high. Each result appears with `out_valid` exactly two clock edges later, in issue order. The lane count must be even.

Top module: `cplx_lane_alu`

## Requirements
- R1: While reset is asserted, and after it is released with no work issued, `out_valid` is 0 and `out_vec` is all zeros.
- R2: Opcode 0 (rotate-90 add): for each pair k, out[2k] = a[2k] - b[2k+1] and out[2k+1] = a[2k+1] + b[2k].
- R3: Opcode 1 (rotate-270 add): out[2k] = a[2k] + b[2k+1] and out[2k+1] = a[2k+1] - b[2k].
- R4: Opcode 2 (multiply): out[2k] = ar*br - ai*bi and out[2k+1] = ar*bi + ai*br, where ar/ai and br/bi are the even/odd lanes of pair k of a and b.
- R5: Opcode 3 (multiply by conjugate): this is the R4 product with bi replaced by -bi. That gives out[2k] = ar*br + ai*bi and out[2k+1] = ai*br - ar*bi.
- R6: Opcode 4 (multiply-accumulate): the R4 product plus pair k of c, added lane by lane.
- R7: Opcode 6 (multiply-subtract): the R4 product minus pair k of c, subtracted lane by lane.
- R8: Opcodes 5 and 7 are the R6 and R7 operations with the R5 conjugate product in place of the R4 product.
- R9: For opcodes 0 to 3, the value on `c_vec` has no effect on the result.
- R10: `out_valid` is high exactly two cycles after each cycle with `in_valid` high, and only then. Back-to-back operations come out one per cycle, in issue order.
- R11: All sums, differences and products keep only the low W bits in two's complement, including at full-scale operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issues an operation this cycle |
| opcode | input | 3 | Operation select (0..7, see requirements) |
| a_vec | input | LANES*W | First operand, lane i at bits [i*W +: W] |
| b_vec | input | LANES*W | Second operand |
| c_vec | input | LANES*W | Third operand for accumulate/subtract opcodes |
| out_valid | output | 1 | Result on `out_vec` is valid |
| out_vec | output | LANES*W | Result vector |

## Verification
Each pair of lanes is computed by its own hardware slice. A fault in one slice shows up only in that pair's two lanes of `out_vec`, and it shows up in the same cycle that `out_valid` rises for the faulty issue, two edges after the input. Faults in the stage-one product or sign registers show up as wrong real or imaginary signs only on the opcodes that use them, and those are told apart by the conjugate and subtract variants. A valid bit lost or duplicated between stages moves the results against the scoreboard order on the very next output cycle. Full-range random operands are issued back to back across all opcodes, so carries out of the lane width and stale pipeline data become visible at once.

// File: rtl/cplx_lane_pkg.sv
package cplx_lane_pkg;

    typedef enum logic [2:0] {
        OP_ROT90   = 3'd0,
        OP_ROT270  = 3'd1,
        OP_MUL     = 3'd2,
        OP_MULCJ   = 3'd3,
        OP_MAC     = 3'd4,
        OP_MACCJ   = 3'd5,
        OP_MSUB    = 3'd6,
        OP_MSUBCJ  = 3'd7
    } cplx_op_e;

    // Final combine selected by opcode[2:1]
    typedef enum logic [1:0] {
        FIN_ROT = 2'd0,
        FIN_MUL = 2'd1,
        FIN_ADD = 2'd2,
        FIN_SUB = 2'd3
    } cplx_fin_e;

    function automatic logic op_is_conj(input logic [2:0] op);
        return op[0] & (op[1] | op[2]);
    endfunction

    function automatic cplx_fin_e op_fin(input logic [2:0] op);
        return cplx_fin_e'(op[2:1]);
    endfunction

endpackage

// File: rtl/cplx_pair_front.sv
// Stage-one arithmetic for one real/imaginary pair: four partial products
// and the rotated sum selected by the rotation direction bit.
module cplx_pair_front #(
    parameter int W = 16
) (
    input  logic         rot270,
    input  logic [W-1:0] ar,
    input  logic [W-1:0] ai,
    input  logic [W-1:0] br,
    input  logic [W-1:0] bi,
    output logic [W-1:0] p_rr,
    output logic [W-1:0] p_ii,
    output logic [W-1:0] p_ri,
    output logic [W-1:0] p_ir,
    output logic [W-1:0] rot_re,
    output logic [W-1:0] rot_im
);

    always_comb begin
        // low W bits of a product do not depend on operand signedness
        p_rr = ar * br;
        p_ii = ai * bi;
        p_ri = ar * bi;
        p_ir = ai * br;
        if (rot270) begin
            rot_re = ar + bi;
            rot_im = ai - br;
        end else begin
            rot_re = ar - bi;
            rot_im = ai + br;
        end
    end

endmodule

// File: rtl/cplx_pair_back.sv
// Stage-two combine for one pair: product signs for plain or conjugate
// multiply, then pass, accumulate or subtract the third operand.
module cplx_pair_back #(
    parameter int W = 16
) (
    input  logic [1:0]   fin,
    input  logic         conj,
    input  logic [W-1:0] p_rr,
    input  logic [W-1:0] p_ii,
    input  logic [W-1:0] p_ri,
    input  logic [W-1:0] p_ir,
    input  logic [W-1:0] rot_re,
    input  logic [W-1:0] rot_im,
    input  logic [W-1:0] cr,
    input  logic [W-1:0] ci,
    output logic [W-1:0] res_re,
    output logic [W-1:0] res_im
);
    import cplx_lane_pkg::*;

    logic [W-1:0] m_re;
    logic [W-1:0] m_im;

    always_comb begin
        if (conj) begin
            m_re = p_rr + p_ii;
            m_im = p_ir - p_ri;
        end else begin
            m_re = p_rr - p_ii;
            m_im = p_ri + p_ir;
        end
        case (cplx_fin_e'(fin))
            FIN_ROT: begin
                res_re = rot_re;
                res_im = rot_im;
            end
            FIN_MUL: begin
                res_re = m_re;
                res_im = m_im;
            end
            FIN_ADD: begin
                res_re = m_re + cr;
                res_im = m_im + ci;
            end
            default: begin
                res_re = m_re - cr;
                res_im = m_im - ci;
            end
        endcase
    end

endmodule

// File: rtl/cplx_lane_alu.sv
module cplx_lane_alu #(
    parameter int LANES = 4,
    parameter int W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [2:0]           opcode,
    input  logic [LANES*W-1:0]   a_vec,
    input  logic [LANES*W-1:0]   b_vec,
    input  logic [LANES*W-1:0]   c_vec,
    output logic                 out_valid,
    output logic [LANES*W-1:0]   out_vec
);
    import cplx_lane_pkg::*;

    localparam int PAIRS = LANES / 2;
    localparam int VW    = LANES * W;
    localparam int PW    = PAIRS * W;

    typedef struct packed {
        logic          vld;
        logic [1:0]    fin;
        logic          conj;
        logic [PW-1:0] prr;
        logic [PW-1:0] pii;
        logic [PW-1:0] pri;
        logic [PW-1:0] pir;
        logic [PW-1:0] rre;
        logic [PW-1:0] rim;
        logic [VW-1:0] acc;
    } stage1_t;

    typedef struct packed {
        logic          vld;
        logic [VW-1:0] res;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [PW-1:0] f_prr, f_pii, f_pri, f_pir, f_rre, f_rim;
    logic [VW-1:0] b_res;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        cplx_pair_front #(.W(W)) i_front (
            .rot270 (opcode[0]),
            .ar     (a_vec[(2*k)*W   +: W]),
            .ai     (a_vec[(2*k+1)*W +: W]),
            .br     (b_vec[(2*k)*W   +: W]),
            .bi     (b_vec[(2*k+1)*W +: W]),
            .p_rr   (f_prr[k*W +: W]),
            .p_ii   (f_pii[k*W +: W]),
            .p_ri   (f_pri[k*W +: W]),
            .p_ir   (f_pir[k*W +: W]),
            .rot_re (f_rre[k*W +: W]),
            .rot_im (f_rim[k*W +: W])
        );

        cplx_pair_back #(.W(W)) i_back (
            .fin    (pipe_q.s1.fin),
            .conj   (pipe_q.s1.conj),
            .p_rr   (pipe_q.s1.prr[k*W +: W]),
            .p_ii   (pipe_q.s1.pii[k*W +: W]),
            .p_ri   (pipe_q.s1.pri[k*W +: W]),
            .p_ir   (pipe_q.s1.pir[k*W +: W]),
            .rot_re (pipe_q.s1.rre[k*W +: W]),
            .rot_im (pipe_q.s1.rim[k*W +: W]),
            .cr     (pipe_q.s1.acc[(2*k)*W   +: W]),
            .ci     (pipe_q.s1.acc[(2*k+1)*W +: W]),
            .res_re (b_res[(2*k)*W   +: W]),
            .res_im (b_res[(2*k+1)*W +: W])
        );
    end

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1.vld = in_valid;
        if (in_valid) begin
            pipe_d.s1.fin  = op_fin(opcode);
            pipe_d.s1.conj = op_is_conj(opcode);
            pipe_d.s1.prr  = f_prr;
            pipe_d.s1.pii  = f_pii;
            pipe_d.s1.pri  = f_pri;
            pipe_d.s1.pir  = f_pir;
            pipe_d.s1.rre  = f_rre;
            pipe_d.s1.rim  = f_rim;
            pipe_d.s1.acc  = c_vec;
        end
        pipe_d.s2.vld = pipe_q.s1.vld;
        if (pipe_q.s1.vld) begin
            pipe_d.s2.res = b_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s2.vld;
    assign out_vec   = pipe_q.s2.res;

endmodule

// File: rtl/cplx_lane_alu_chk.sv
module cplx_lane_alu_chk #(
    parameter int LANES = 4,
    parameter int W     = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [2:0]         opcode,
    input logic [LANES*W-1:0] a_vec,
    input logic [LANES*W-1:0] b_vec,
    input logic [LANES*W-1:0] c_vec,
    input logic               out_valid,
    input logic [LANES*W-1:0] out_vec
);

    // R10: fixed two-edge latency of the valid flag
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 2));

    // R2: real lane of pair 0 under rotate-90
    a_r2_rot90_real: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(opcode, 2) == 3'd0) |->
        out_vec[W-1:0] == $past(a_vec[W-1:0] - b_vec[2*W-1:W], 2));

    // R3: imaginary lane of pair 0 under rotate-270
    a_r3_rot270_imag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(opcode, 2) == 3'd1) |->
        out_vec[2*W-1:W] == $past(a_vec[2*W-1:W] - b_vec[W-1:0], 2));

    // R6: with a zero first multiplicand, accumulate returns the third operand
    a_r6_mac_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && opcode == 3'd4 && a_vec == '0, 2) |->
        out_vec == $past(c_vec, 2));

    // R7: with a zero second multiplicand, subtract returns minus the third operand
    a_r7_msub_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && opcode == 3'd6 && b_vec == '0, 2) |->
        (out_vec[W-1:0] + $past(c_vec[W-1:0], 2)) == W'(0));

endmodule

bind cplx_lane_alu cplx_lane_alu_chk #(.LANES(LANES), .W(W)) i_chk (.*);

// File: tb/test_cplx_lane_alu.sv
`timescale 1ns/1ps
module test_cplx_lane_alu;

    localparam int LANES = 4;
    localparam int W     = 16;
    localparam int VW    = LANES * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    opcode = 3'd0;
    logic [VW-1:0] a_vec = '0;
    logic [VW-1:0] b_vec = '0;
    logic [VW-1:0] c_vec = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [VW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    cplx_lane_alu #(.LANES(LANES), .W(W)) i_cplx_lane_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .a_vec(a_vec), .b_vec(b_vec), .c_vec(c_vec),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [VW-1:0] model(input logic [2:0] op,
        input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] c);
        logic [VW-1:0] r;
        r = '0;
        for (int k = 0; k < LANES / 2; k++) begin
            logic [W-1:0] ar, ai, br, bi, cr, ci, bx, mr, mi, rr, ri;
            ar = a[(2*k)*W +: W];  ai = a[(2*k+1)*W +: W];
            br = b[(2*k)*W +: W];  bi = b[(2*k+1)*W +: W];
            cr = c[(2*k)*W +: W];  ci = c[(2*k+1)*W +: W];
            bx = (op == 3'd3 || op == 3'd5 || op == 3'd7) ? W'(0) - bi : bi;
            mr = ar * br - ai * bx;
            mi = ar * bx + ai * br;
            case (op)
                3'd0: begin rr = ar - bi; ri = ai + br; end
                3'd1: begin rr = ar + bi; ri = ai - br; end
                3'd2, 3'd3: begin rr = mr; ri = mi; end
                3'd4, 3'd5: begin rr = mr + cr; ri = mi + ci; end
                default: begin rr = mr - cr; ri = mi - ci; end
            endcase
            r[(2*k)*W +: W]   = rr;
            r[(2*k+1)*W +: W] = ri;
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] pack4(input int l0, input int l1,
        input int l2, input int l3);
        return {W'(l3), W'(l2), W'(l1), W'(l0)};
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW; i += 32) v[i +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input string tag, input logic [VW-1:0] got,
        input logic [VW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [VW-1:0] a,
        input logic [VW-1:0] b, input logic [VW-1:0] c, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        opcode   = op;
        a_vec    = a;
        b_vec    = b;
        c_vec    = c;
        exp_q.push_back(model(op, a, b, c));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a_vec    = rnd_vec();
        end
    endtask

    // Monitor: pops the scoreboard whenever a result is presented (R10 order)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10: actual out_valid 1 expected 0 (no pending issue)");
            end else begin
                check(tag_q.pop_front(), out_vec, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] ra, rb;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            errors++;
            $display("FAIL R1: actual %b/%h expected 0/0", out_valid, out_vec);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            errors++;
            $display("FAIL R1: actual %b/%h expected 0/0 after release", out_valid, out_vec);
        end

        // directed pairs: (3+4i) and (1+2i), (-2+5i) and (7-3i)
        send(3'd0, pack4(1, 2, 3, 4), pack4(10, 20, 30, 40), '0, "R2 rot90");
        send(3'd1, pack4(1, 2, 3, 4), pack4(10, 20, 30, 40), '0, "R3 rot270");
        send(3'd2, pack4(3, 4, -2, 5), pack4(1, 2, 7, -3), '0, "R4 mul");
        send(3'd3, pack4(3, 4, -2, 5), pack4(1, 2, 7, -3), '0, "R5 conj mul");
        send(3'd4, pack4(3, 4, -2, 5), pack4(1, 2, 7, -3), pack4(100, -50, 9, 8), "R6 mac");
        send(3'd6, pack4(3, 4, -2, 5), pack4(1, 2, 7, -3), pack4(100, -50, 9, 8), "R7 msub");
        send(3'd5, pack4(3, 4, -2, 5), pack4(1, 2, 7, -3), pack4(100, -50, 9, 8), "R8 conj mac");
        send(3'd7, pack4(3, 4, -2, 5), pack4(1, 2, 7, -3), pack4(100, -50, 9, 8), "R8 conj msub");
        idle(3);

        // R9: c is ignored for opcodes 0..3 (model never reads it there)
        for (int op = 0; op < 4; op++) begin
            ra = rnd_vec();
            rb = rnd_vec();
            send(3'(op), ra, rb, '0, "R9 c zero");
            send(3'(op), ra, rb, {VW{1'b1}}, "R9 c ones");
            send(3'(op), ra, rb, rnd_vec(), "R9 c random");
        end
        idle(2);

        // R11: full-scale operands wrap
        send(3'd2, pack4(32767, 32767, -32768, -32768), pack4(32767, -32768, -32768, -32768),
             '0, "R11 wrap mul");
        send(3'd0, pack4(-32768, 32767, 0, 0), pack4(1, 1, 1, 1), '0, "R11 wrap rot90");
        send(3'd4, pack4(-32768, -32768, 32767, 32767), pack4(-1, 0, 32767, 32767),
             pack4(32767, -32768, 32767, -32768), "R11 wrap mac");
        send(3'd7, pack4(-32768, 1, 2, -32768), pack4(-32768, -32768, 3, 4),
             pack4(-32768, 32767, -1, 1), "R11 wrap conj msub");
        idle(1);

        // R10: back-to-back random traffic across all opcodes, with gaps
        for (int n = 0; n < 300; n++) begin
            send(3'($urandom_range(0, 7)), rnd_vec(), rnd_vec(), rnd_vec(), "R10 stream");
            if (n % 37 == 36) idle(1 + n % 3);
        end
        idle(4);

        // R10: nothing left pending and valid has dropped
        checks++;
        if (exp_q.size() != 0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10: actual pending %0d valid %b expected 0 0", exp_q.size(), out_valid);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule